// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The guess is ready in the same cycle the fetch address is presented. A tagless table of 2-bit counters, selected by the fetch address alone, always gives a default guess. Three tagged tables refine that guess. Each tagged table selects an entry by mixing the fetch address with a longer slice of the global outcome history: the newest 4, 8 and 16 outcomes, so each length is double the one before. Every tagged entry holds a 3-bit two's-complement direction counter, an 8-bit partial tag and a usefulness bit. The guess comes from the hitting table that uses the longest history. If no tag matches, the tagless table decides.

Lookup is purely combinational, so it has no handshake and no back-pressure. The update side is a valid-qualified stream with no ready signal. The block accepts a resolved branch on every cycle that `upd_valid` is high and can never stall the pipeline that retires branches. The pipeline reports the address, the real outcome and whether the front end mispredicted it. An update first re-reads the tables with the current history. It then trains the providing counter, adjusts the provider's usefulness bit, and on a mispredict claims one free entry in a table with longer history than the provider. If every such entry is marked useful, it clears their usefulness bits and claims none. Last, it shifts the outcome into the history register. A tag value of zero is reserved to mean "empty", so entries cleared at reset can never hit.

Top module: `tage_predictor`

## Requirements
- R1: After reset, every address predicts not-taken. Tagged counters reset to 3'b111 (weak not-taken), tags to zero (empty), usefulness bits to zero, base counters to 2'b01 and the history to zero. The first lookup after reset release is already valid.
- R2: The tagless counter is selected by address bits [9:2]. It predicts taken when its value is 2 or 3. An update with no tag hit moves it by one toward the outcome, saturating at 0 and 3.
- R3: Training one tagless counter leaves the counters at other values of address bits [9:2] unchanged.
- R4: An update flagged as mispredicted with no tagged hit allocates an entry in the 4-outcome table. The entry gets the update's tag, a counter of 3'b000 for taken or 3'b111 for not-taken, and a clear usefulness bit. When the same address meets the same newest four outcomes again, that entry's counter sign overrides the tagless guess.
- R5: When several tagged tables hit, the one with the longest history supplies the guess and is the only counter trained.
- R6: An update without the mispredict flag never allocates a tagged entry.
- R7: A single branch that repeats taken, taken, taken, not-taken is predicted without error once trained: no mispredict in 100 branches after 300 updates from reset.
- R8: A lookup changes no state, and the update inputs have no effect while `upd_valid` is low.
- R9: The 16-bit history shifts the outcome into bit 0 on every accepted update and holds otherwise. Tagged table k (k = 0, 1, 2) hashes only the newest 4·2^k history bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | 32 | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction for `lk_pc`, 1 = taken, combinational |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_mispred | input | 1 | The front end mispredicted this branch |

## Verification
The embedded properties check the following on every cycle:
- the history shift on each accepted update and its stability between updates;
- that a table write lands at the addressed entry;
- that allocation never happens without the mispredict flag;
- the not-taken output right after reset.

Only the directed scenarios can show the rest, because it depends on long update sequences and on the history returning to an earlier value:
- that an allocated entry wins over the tagless guess;
- that the longest matching table beats a shorter one;
- that the tagless counters saturate and stay independent per address;
- that a repeating loop pattern is eventually learnt.

// File: rtl/tage_pkg.sv
package tage_pkg;
  localparam int PC_W       = 32;
  localparam int PC_LSB     = 2;
  localparam int GHR_W      = 16;
  localparam int NUM_TAB    = 3;
  localparam int TAB_IDX_W  = 6;
  localparam int TAG_W      = 8;
  localparam int CTR_W      = 3;
  localparam int BASE_IDX_W = 8;
  localparam int BASE_CTR_W = 2;
  localparam int PCB_W      = TAB_IDX_W + TAG_W;
  localparam int TAB_SEL_W  = $clog2(NUM_TAB);
  localparam int MIN_HIST   = 4;

  typedef struct packed {
    logic [CTR_W-1:0] ctr;
    logic [TAG_W-1:0] tag;
    logic             u;
  } tent_t;

  // geometric history length of table k
  function automatic int hist_len(int k);
    return MIN_HIST << k;
  endfunction

  function automatic logic [TAB_IDX_W-1:0] fold_idx(logic [GHR_W-1:0] h, int len);
    logic [TAB_IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < GHR_W; i++)
      if (i < len) r[i % TAB_IDX_W] ^= h[i];
    return r;
  endfunction

  // different fold for the tag: bit positions rotated by three
  function automatic logic [TAG_W-1:0] fold_tag(logic [GHR_W-1:0] h, int len);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = 0; i < GHR_W; i++)
      if (i < len) r[(i + 3) % TAG_W] ^= h[i];
    return r;
  endfunction

  function automatic logic [CTR_W-1:0] ctr_step(logic [CTR_W-1:0] c, logic up);
    logic [CTR_W-1:0] hi, lo;
    hi = {1'b0, {(CTR_W-1){1'b1}}};
    lo = {1'b1, {(CTR_W-1){1'b0}}};
    if (up) return (c == hi) ? c : c + CTR_W'(1);
    else    return (c == lo) ? c : c - CTR_W'(1);
  endfunction
endpackage

// File: rtl/tage_hist.sv
module tage_hist
  import tage_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic             upd_taken,
  output logic [GHR_W-1:0] ghr
);
  always_ff @(posedge clk) begin
    if (!rst_n)         ghr <= '0;
    else if (upd_valid) ghr <= {ghr[GHR_W-2:0], upd_taken};
  end

  // R9: newest outcome enters bit 0, older bits move up by one
  p_hist_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghr[0] == $past(upd_taken)) && (ghr[GHR_W-1:1] == $past(ghr[GHR_W-2:0])));

  // R9: no update, no movement
  p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr));
endmodule

// File: rtl/tage_base.sv
module tage_base
  import tage_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BASE_IDX_W-1:0] lk_idx,
  input  logic [BASE_IDX_W-1:0] up_idx,
  input  logic                  we,
  input  logic [BASE_CTR_W-1:0] wctr,
  output logic [BASE_CTR_W-1:0] lk_ctr,
  output logic [BASE_CTR_W-1:0] up_ctr
);
  localparam int DEPTH = 1 << BASE_IDX_W;
  localparam logic [BASE_CTR_W-1:0] WEAK_NT = {1'b0, {(BASE_CTR_W-1){1'b1}}};

  logic [BASE_CTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_NT;
    end else if (we) begin
      mem[up_idx] <= wctr;
    end
  end

  assign lk_ctr = mem[lk_idx];
  assign up_ctr = mem[up_idx];
endmodule

// File: rtl/tage_bank.sv
module tage_bank
  import tage_pkg::*;
#(
  parameter int HLEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCB_W-1:0] lk_pcb,
  input  logic [PCB_W-1:0] up_pcb,
  input  logic [GHR_W-1:0] ghr,
  input  logic             we,
  input  tent_t            wdata,
  output logic             lk_hit,
  output logic             lk_dir,
  output logic             up_hit,
  output tent_t            up_ent,
  output logic [TAG_W-1:0] up_tag
);
  localparam int DEPTH = 1 << TAB_IDX_W;

  function automatic logic [TAB_IDX_W-1:0] idx_of(logic [PCB_W-1:0] pcb, logic [GHR_W-1:0] h);
    return pcb[TAB_IDX_W-1:0] ^ fold_idx(h, HLEN);
  endfunction

  // zero is the empty marker, so a computed zero tag is moved to one
  function automatic logic [TAG_W-1:0] tag_of(logic [PCB_W-1:0] pcb, logic [GHR_W-1:0] h);
    logic [TAG_W-1:0] t;
    t = pcb[TAB_IDX_W +: TAG_W] ^ fold_tag(h, HLEN);
    return (t == '0) ? TAG_W'(1) : t;
  endfunction

  tent_t mem [DEPTH];
  logic [TAB_IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0]     lk_tag;

  assign lk_idx = idx_of(lk_pcb, ghr);
  assign lk_tag = tag_of(lk_pcb, ghr);
  assign up_idx = idx_of(up_pcb, ghr);
  assign up_tag = tag_of(up_pcb, ghr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '{ctr: '1, tag: '0, u: 1'b0};
    end else if (we) begin
      mem[up_idx] <= wdata;
    end
  end

  assign lk_hit = (mem[lk_idx].tag == lk_tag);
  assign lk_dir = ~mem[lk_idx].ctr[CTR_W-1];
  assign up_hit = (mem[up_idx].tag == up_tag);
  assign up_ent = mem[up_idx];

  // R4: a write from the update logic lands at the entry the update selected
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(up_idx)] == $past(wdata));
endmodule

// File: rtl/tage_predictor.sv
module tage_predictor
  import tage_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_mispred
);
  logic [GHR_W-1:0]      ghr;
  logic [BASE_CTR_W-1:0] base_lk, base_up, base_wctr;
  logic                  base_we;

  logic [NUM_TAB-1:0] lk_hit, lk_dir, up_hit, bank_we, uvec, elig, free, alloc_vec;
  tent_t              up_ent  [NUM_TAB];
  tent_t              bank_wd [NUM_TAB];
  logic [TAG_W-1:0]   up_tag  [NUM_TAB];

  logic                 has_prov, prov_dir, alt_dir;
  logic [TAB_SEL_W-1:0] prov;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_LSB-1:0], lk_pc[PC_W-1:PC_LSB+PCB_W],
                            upd_pc[PC_LSB-1:0], upd_pc[PC_W-1:PC_LSB+PCB_W]};

  tage_hist u_hist (
    .clk, .rst_n, .upd_valid, .upd_taken, .ghr
  );

  tage_base u_base (
    .clk, .rst_n,
    .lk_idx (lk_pc[PC_LSB +: BASE_IDX_W]),
    .up_idx (upd_pc[PC_LSB +: BASE_IDX_W]),
    .we     (base_we),
    .wctr   (base_wctr),
    .lk_ctr (base_lk),
    .up_ctr (base_up)
  );

  for (genvar g = 0; g < NUM_TAB; g++) begin : g_bank
    tage_bank #(.HLEN(hist_len(g))) u_bank (
      .clk, .rst_n,
      .lk_pcb (lk_pc[PC_LSB +: PCB_W]),
      .up_pcb (upd_pc[PC_LSB +: PCB_W]),
      .ghr,
      .we     (bank_we[g]),
      .wdata  (bank_wd[g]),
      .lk_hit (lk_hit[g]),
      .lk_dir (lk_dir[g]),
      .up_hit (up_hit[g]),
      .up_ent (up_ent[g]),
      .up_tag (up_tag[g])
    );
    assign uvec[g] = up_ent[g].u;
  end

  // lookup: longest hitting table wins, tagless table as default
  always_comb begin
    lk_taken = base_lk[BASE_CTR_W-1];
    for (int k = 0; k < NUM_TAB; k++)
      if (lk_hit[k]) lk_taken = lk_dir[k];
  end

  // update-side provider and alternate
  always_comb begin
    has_prov = 1'b0;
    prov     = '0;
    prov_dir = base_up[BASE_CTR_W-1];
    alt_dir  = base_up[BASE_CTR_W-1];
    for (int k = 0; k < NUM_TAB; k++) begin
      if (up_hit[k]) begin
        alt_dir  = prov_dir;
        prov_dir = ~up_ent[k].ctr[CTR_W-1];
        prov     = TAB_SEL_W'(k);
        has_prov = 1'b1;
      end
    end
  end

  // allocation candidates: longer than the provider, on a mispredict only
  always_comb begin
    for (int k = 0; k < NUM_TAB; k++)
      elig[k] = upd_valid && upd_mispred && (!has_prov || (k > int'(prov)));
    free      = elig & ~uvec;
    alloc_vec = free & (~free + NUM_TAB'(1));
  end

  always_comb begin
    base_we   = upd_valid && !has_prov;
    base_wctr = base_up;
    if (upd_taken && base_up != '1)      base_wctr = base_up + BASE_CTR_W'(1);
    else if (!upd_taken && base_up != '0) base_wctr = base_up - BASE_CTR_W'(1);

    for (int k = 0; k < NUM_TAB; k++) begin
      bank_we[k] = 1'b0;
      bank_wd[k] = up_ent[k];
      if (upd_valid && has_prov && (k == int'(prov))) begin
        bank_we[k]     = 1'b1;
        bank_wd[k].ctr = ctr_step(up_ent[k].ctr, upd_taken);
        if (prov_dir != alt_dir) bank_wd[k].u = (prov_dir == upd_taken);
      end else if (alloc_vec[k]) begin
        bank_we[k] = 1'b1;
        bank_wd[k] = '{ctr: upd_taken ? '0 : '1, tag: up_tag[k], u: 1'b0};
      end else if (elig[k] && (free == '0)) begin
        bank_we[k]   = 1'b1;
        bank_wd[k].u = 1'b0;
      end
    end
  end

  // R1: the cycle after reset every lookup says not-taken
  p_reset_nt_r1: assert property (@(posedge clk)
    !rst_n |=> !lk_taken);

  // R6: no claim of a new entry unless the branch was flagged mispredicted
  p_no_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_mispred) |-> (alloc_vec == '0));
endmodule

// File: tb/sim_tage_predictor.sv
`timescale 1ns/1ps
module sim_tage_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        upd_mispred = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] PC_P = 32'h1000_0100;
  localparam logic [31:0] PC_X = 32'h2000_0300;
  localparam logic [31:0] PC_Y = 32'h0000_0204;

  always #4 clk = ~clk;

  tage_predictor u0 (
    .clk, .rst_n, .lk_pc, .lk_taken,
    .upd_valid, .upd_pc, .upd_taken, .upd_mispred
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic t, input logic m);
    @(negedge clk);
    upd_pc = pc; upd_taken = t; upd_mispred = m; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, output logic p);
    lk_pc = pc;
    #1;
    p = lk_taken;
  endtask

  // sixteen not-taken updates on an unrelated address clear the history
  task automatic rewind(input int n);
    for (int i = 0; i < n; i++) upd(PC_X, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    logic p;
    apply_reset();
    look(PC_P, p); check("R1 reset P", p, 1'b0);
    look(PC_X, p); check("R1 reset X", p, 1'b0);
    look(32'hFFFF_FFFC, p); check("R1 reset high address", p, 1'b0);
  endtask

  task automatic t_base();
    logic p;
    apply_reset();
    upd(PC_P, 1'b1, 1'b0);
    look(PC_P, p); check("R2 one taken flips weak counter", p, 1'b1);
    upd(PC_P, 1'b1, 1'b0); upd(PC_P, 1'b1, 1'b0);
    upd(PC_P, 1'b0, 1'b0);
    look(PC_P, p); check("R2 saturated counter keeps taken after one not-taken", p, 1'b1);
    upd(PC_P, 1'b0, 1'b0);
    look(PC_P, p); check("R2 second not-taken turns prediction", p, 1'b0);
    upd(PC_Y, 1'b1, 1'b0); upd(PC_Y, 1'b1, 1'b0);
    look(PC_P, p); check("R3 training other index leaves P", p, 1'b0);
    look(PC_Y, p); check("R3 other index trained", p, 1'b1);
  endtask

  task automatic t_alloc();
    logic p;
    apply_reset();
    upd(PC_P, 1'b1, 1'b1);        // allocate at history zero
    upd(PC_P, 1'b0, 1'b0);        // history one, no hit: base back to weak not-taken
    look(PC_P, p); check("R9 entry misses under other history", p, 1'b0);
    rewind(14);                   // only bit 15 of history set
    look(PC_P, p); check("R9 short table sees only newest bits", p, 1'b1);
    rewind(1);
    look(PC_P, p); check("R4 allocated entry overrides base", p, 1'b1);
  endtask

  task automatic t_longest();
    logic p;
    apply_reset();
    upd(PC_P, 1'b1, 1'b1);        // short table entry, weak taken
    upd(PC_P, 1'b0, 1'b0);        // base weak not-taken
    rewind(16);
    upd(PC_P, 1'b0, 1'b1);        // short goes not-taken, longer entry allocated
    rewind(16);
    upd(PC_P, 1'b1, 1'b0);        // longer entry trained to taken
    rewind(16);
    look(PC_P, p); check("R5 longest hit supplies prediction", p, 1'b1);
  endtask

  task automatic t_no_alloc();
    logic p;
    apply_reset();
    upd(PC_P, 1'b1, 1'b0);
    upd(PC_P, 1'b0, 1'b0);
    rewind(16);
    look(PC_P, p); check("R6 no entry without mispredict flag", p, 1'b0);
  endtask

  task automatic t_idle();
    logic p;
    apply_reset();
    upd(PC_P, 1'b1, 1'b0);
    @(negedge clk);
    upd_pc = PC_P; upd_taken = 1'b0; upd_mispred = 1'b1;
    for (int i = 0; i < 6; i++) begin
      lk_pc = 32'h0000_1000 + 32'(i * 4);
      @(negedge clk);
    end
    look(PC_P, p); check("R8 lookups and idle update inputs change nothing", p, 1'b1);
  endtask

  task automatic t_loop();
    logic p, o;
    int miss;
    miss = 0;
    apply_reset();
    for (int it = 0; it < 100; it++) begin
      for (int s = 0; s < 4; s++) begin
        o = (s != 3);
        look(PC_P, p);
        if (it >= 75 && p != o) miss++;
        upd(PC_P, o, p != o);
      end
    end
    checks++;
    if (miss != 0) begin
      errors++;
      $display("FAIL R7 loop pattern mispredicts: got %0d expected 0", miss);
    end
  endtask

  initial begin
    t_reset();
    t_base();
    t_alloc();
    t_longest();
    t_no_alloc();
    t_idle();
    t_loop();
    t_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all: watchdog got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule